// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects a parameterized set of interrupt request lines and delivers them to a small number of hart contexts. Source number 0 is reserved and never raises a request. Each source passes through a gateway, which turns the raw line into a single pending request. Each source also has a small priority value.

Each context holds three things: an enable bit per source, a priority threshold, and a claim/complete register. A context's output line goes high when at least one source is enabled for it, pending, and above its threshold. Software reads the claim register to take the best request. It writes the same ID back to that register once the request has been handled.

All registers sit behind a plain 32-bit word read/write port. Read data appears one cycle after the request and is held until the next read. A build parameter selects the gateway type for all sources: level-sampled or rising-edge-capturing.

Top module: `irq_hub`

## Requirements
- R1: After reset every context output is low. Every priority, enable and threshold register reads 0, every claim read returns 0, and `rdata_o` is 0.
- R2: Source k's priority is the word at byte address 4·k. Only bits [2:0] are stored; the upper bits read 0. The word for source 0 always reads 0 and ignores writes.
- R3: Context c's enable word w is at byte 0x2000 + 0x80·c + 4·w. Bit b of that word enables source 32·w + b. Bit 0 of word 0 (source 0) and bits beyond the last source always read 0.
- R4: Context c's threshold is at byte 0x200000 + 0x1000·c. It holds 3 bits, and its upper bits read 0.
- R5: `irq_o[c]` is high exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. A threshold of 7 masks all sources, and a priority of 0 never interrupts.
- R6: A read of byte 0x200004 + 0x1000·c returns the ID of the eligible source with the highest priority; on a tie the lowest ID wins. It returns 0 if no source is eligible. A nonzero return clears that source's pending bit and marks the source claimed.
- R7: A claimed source cannot become pending again until a completion write to a claim register carries its ID.
- R8: A completion write is ignored if its ID is not currently claimed, or if the ID is not enabled for the context whose claim register was written.
- R9: In level mode, a line that is high while the source is neither pending nor claimed makes the source pending, and stays pending even if the line drops. After completion the line is sampled again, so a line that is still high pends the source again within two cycles.
- R10: In edge mode, only a rising edge makes a source pending. A line held high does not pend the source again after completion, and a rising edge that occurs while the source is claimed is lost.
- R11: `rdata_o` changes only on a read, one cycle after the request. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt lines; bit k is source k (k = 1..N_SRC) |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | N_CTX | Per-context interrupt line |

## Verification
The hardest states to reach from the ports are the windows in which a source is claimed but not yet completed. Inside such a window the bench lowers and raises the line, sends completion writes from a context that does not have the source enabled, and changes thresholds. The bench reaches these windows through a fixed order of claim reads and completion writes on a shared register port. A second instance built in edge mode receives the same register traffic. Its lines are toggled while the source is claimed, which shows that edges arriving in that window are dropped.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [11:0] PRIO_PAGE = 12'h000;
  localparam logic [11:0] EN_PAGE   = 12'h002;
  localparam logic [2:0]  CTL_TOP   = 3'b001;
  localparam logic [11:0] OFS_THR   = 12'h000;
  localparam logic [11:0] OFS_CLAIM = 12'h004;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);
  logic src_q, trig;

  assign trig = EDGE ? (src_i & ~src_q) : src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      src_q <= src_i;
      if (claim_i) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else begin
        if (done_i) busy_o <= 1'b0;
        // held off while claimed; re-sampled the cycle after completion
        if (!busy_o && !pend_o && trig) pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int N_SRC  = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [N_SRC:0]             pend_i,
  input  logic [N_SRC:0]             en_i,
  input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]          thr_i,
  output logic [ID_W-1:0]            id_o,
  output logic                       irq_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    id_o   = '0;
    best_p = '0;
    // ascending scan with strict compare keeps the lowest ID on ties
    for (int i = 1; i <= N_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] > best_p)) begin
        id_o   = ID_W'(i);
        best_p = prio_i[i];
      end
    end
  end

  assign irq_o = (id_o != '0);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC     = 31,
  parameter int N_CTX     = 2,
  parameter int PRIO_W    = 3,
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC:1]   src_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [23:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic [N_CTX-1:0] irq_o
);
  localparam int ID_W    = $clog2(N_SRC + 1);
  localparam int N_WORDS = (N_SRC + 32) / 32;
  localparam int EN_W    = N_WORDS * 32;
  localparam int CTX_W   = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int WRD_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  function automatic logic [EN_W-1:0] en_valid();
    logic [EN_W-1:0] m;
    for (int i = 0; i < EN_W; i++) m[i] = (i >= 1) && (i <= N_SRC);
    return m;
  endfunction
  localparam logic [EN_W-1:0] EN_MASK = en_valid();

  logic [N_SRC:0][PRIO_W-1:0]  prio_q;
  logic [N_CTX-1:0][EN_W-1:0]  en_q;
  logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [N_CTX-1:0][ID_W-1:0]  best_id;
  logic [N_SRC:0]              pend, busy, claim_vec, done_vec;

  region_e           region;
  logic [ID_W-1:0]   a_src;
  logic [CTX_W-1:0]  a_ectx, a_cctx;
  logic [WRD_W-1:0]  a_word;
  logic              rd_en, wr_en;
  logic [31:0]       rd_d;

  assign rd_en  = req_i && !we_i;
  assign wr_en  = req_i && we_i;
  assign a_src  = addr_i[2 +: ID_W];
  assign a_ectx = addr_i[7 +: CTX_W];
  assign a_word = addr_i[2 +: WRD_W];
  assign a_cctx = addr_i[12 +: CTX_W];

  always_comb begin
    region = RG_NONE;
    if (addr_i[23:12] == PRIO_PAGE && addr_i[1:0] == 2'b00) begin
      if (int'(addr_i[11:2]) <= N_SRC) region = RG_PRIO;
    end else if (addr_i[23:12] == EN_PAGE && addr_i[1:0] == 2'b00) begin
      if (int'(addr_i[11:7]) < N_CTX && int'(addr_i[6:2]) < N_WORDS) region = RG_EN;
    end else if (addr_i[23:21] == CTL_TOP && int'(addr_i[20:12]) < N_CTX) begin
      if (addr_i[11:0] == OFS_THR)        region = RG_THR;
      else if (addr_i[11:0] == OFS_CLAIM) region = RG_CLAIM;
    end
  end

  // claim and completion pulses per source
  assign claim_vec[0] = 1'b0;
  assign done_vec[0]  = 1'b0;
  assign pend[0]      = 1'b0;
  assign busy[0]      = 1'b0;

  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    assign claim_vec[i] = rd_en && (region == RG_CLAIM) && (best_id[a_cctx] == ID_W'(i));
    assign done_vec[i]  = wr_en && (region == RG_CLAIM) && (wdata_i == 32'(i))
                          && busy[i] && en_q[a_cctx][i];
    irq_gateway #(.EDGE(EDGE_MODE)) u_gw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[i]),
      .claim_i(claim_vec[i]),
      .done_i (done_vec[i]),
      .pend_o (pend[i]),
      .busy_o (busy[i])
    );
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    irq_ctx_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .pend_i(pend),
      .en_i  (en_q[c][N_SRC:0]),
      .prio_i(prio_q),
      .thr_i (thr_q[c]),
      .id_o  (best_id[c]),
      .irq_o (irq_o[c])
    );
  end

  always_comb begin
    rd_d = '0;
    unique case (region)
      RG_PRIO:  rd_d = 32'(prio_q[a_src]);
      RG_EN: begin
        for (int w = 0; w < N_WORDS; w++)
          if (int'(a_word) == w) rd_d = en_q[a_ectx][w*32 +: 32];
      end
      RG_THR:   rd_d = 32'(thr_q[a_cctx]);
      RG_CLAIM: rd_d = 32'(best_id[a_cctx]);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (rd_en) rdata_o <= rd_d;
      if (wr_en) begin
        if (region == RG_PRIO && a_src != '0)
          prio_q[a_src] <= wdata_i[PRIO_W-1:0];
        if (region == RG_EN) begin
          for (int w = 0; w < N_WORDS; w++)
            if (int'(a_word) == w)
              en_q[a_ectx][w*32 +: 32] <= wdata_i & EN_MASK[w*32 +: 32];
        end
        if (region == RG_THR)
          thr_q[a_cctx] <= wdata_i[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_SRC = 31,
  parameter int N_CTX = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [31:0]      rdata_o,
  input logic [N_CTX-1:0] irq_o,
  input logic [N_SRC:0]   pend_i,
  input logic [N_SRC:0]   busy_i
);
  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    AST_CLAIMED_NOT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[i] |-> !pend_i[i]); // R7
    AST_CLAIM_FROM_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_i[i]) |-> $past(pend_i[i])); // R6
  end

  AST_ONE_CLAIM_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_i & ~$past(busy_i)) <= 1); // R6

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|pend_i)); // R5

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R11
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .pend_i (pend),
  .busy_i (busy)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src0 = '0, src1 = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [1:0]  irq0, irq1;
  int          nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  irq_hub u0 (.clk_i(clk), .rst_ni(rst_n), .src_i(src0), .req_i(req), .we_i(we),
              .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .irq_o(irq0));
  irq_hub #(.EDGE_MODE(1'b1)) u1 (.clk_i(clk), .rst_ni(rst_n), .src_i(src1), .req_i(req),
              .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1));

  localparam logic [23:0] CLAIM0 = 24'h200004, CLAIM1 = 24'h201004;
  localparam logic [23:0] THR0 = 24'h200000, THR1 = 24'h201000;
  localparam logic [23:0] EN0 = 24'h002000, EN1 = 24'h002080;

  // address, write data, expected read-back
  localparam logic [87:0] TBL [8] = '{
    {24'h000004, 32'hFFFF_FFFD, 32'h0000_0005},  // R2 upper bits dropped
    {24'h000000, 32'h0000_0007, 32'h0000_0000},  // R2 source 0
    {24'h00007C, 32'h0000_0002, 32'h0000_0002},  // R2 last source
    {EN0,        32'hFFFF_FFFF, 32'hFFFF_FFFE},  // R3 bit 0 read-only
    {EN1,        32'h0000_0401, 32'h0000_0400},  // R3 context 1
    {THR1,       32'h0000_000F, 32'h0000_0007},  // R4
    {THR0,       32'h0000_0003, 32'h0000_0003},  // R4
    {24'h100000, 32'h0000_0005, 32'h0000_0000}   // R11 unmapped
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    d0 = rdata0; d1 = rdata1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1;
    idle(2); rst_n = 1'b1; idle(1);

    // R1 reset state
    check("R1 irq", 32'(irq0), 32'h0);
    check("R1 rdata", rdata0, 32'h0);
    rd(24'h000004, r0, r1); check("R1 prio", r0, 32'h0);
    rd(CLAIM0, r0, r1);     check("R1 claim", r0, 32'h0);

    // register map table
    foreach (TBL[k]) begin
      wr(TBL[k][87:64], TBL[k][63:32]);
      rd(TBL[k][87:64], r0, r1);
      check($sformatf("R2/R3/R4/R11 table entry %0d", k), r0, TBL[k][31:0]);
    end

    // directed setup
    wr(24'h000004, 0); wr(24'h00007C, 0);
    wr(THR0, 0); wr(THR1, 0);
    wr(EN0, 32'h488); wr(EN1, 32'h400);
    wr(24'h00000C, 5); wr(24'h00001C, 5); wr(24'h000028, 2);

    src0[10] = 1'b1; idle(3);
    check("R5 ctx0 up", 32'(irq0[0]), 32'h1);
    check("R5 ctx1 up", 32'(irq0[1]), 32'h1);
    wr(THR1, 2); idle(1);
    check("R5 strict compare", 32'(irq0[1]), 32'h0);
    wr(THR1, 1); idle(1);
    check("R5 below threshold", 32'(irq0[1]), 32'h1);

    src0[3] = 1'b1; src0[7] = 1'b1; idle(3);
    rd(CLAIM0, r0, r1); check("R6 tie lowest id", r0, 32'd3);
    wr(THR0, 0);
    check("R11 rdata held across write", rdata0, 32'd3);
    rd(CLAIM0, r0, r1); check("R6 second", r0, 32'd7);
    rd(CLAIM0, r0, r1); check("R6 lower prio", r0, 32'd10);
    idle(2);
    check("R7 all claimed", 32'(irq0), 32'h0);
    rd(CLAIM1, r0, r1); check("R6 empty claim", r0, 32'd0);

    wr(CLAIM1, 3); idle(3);
    rd(CLAIM0, r0, r1); check("R8 complete from wrong ctx", r0, 32'd0);
    wr(CLAIM0, 3); idle(3);
    check("R9 re-pend high line", 32'(irq0[0]), 32'h1);
    rd(CLAIM0, r0, r1); check("R9 reclaim", r0, 32'd3);
    src0[3] = 1'b0; wr(CLAIM0, 3); idle(3);
    check("R9 low line stays idle", 32'(irq0[0]), 32'h0);

    wr(24'h000030, 4); wr(EN0, 32'h1488);
    @(negedge clk); src0[12] = 1'b1;
    @(negedge clk); src0[12] = 1'b0;
    idle(3);
    check("R9 pending latched", 32'(irq0[0]), 32'h1);
    rd(CLAIM0, r0, r1); check("R9 latched id", r0, 32'd12);
    wr(CLAIM0, 12); wr(CLAIM0, 12); idle(3);
    check("R8 repeat completion", 32'(irq0[0]), 32'h0);

    wr(CLAIM0, 7); idle(3);
    check("R5 pending again", 32'(irq0[0]), 32'h1);
    wr(THR0, 7); idle(1);
    check("R5 threshold 7 masks", 32'(irq0[0]), 32'h0);
    wr(THR0, 0); idle(1);
    check("R5 threshold 0 allows", 32'(irq0[0]), 32'h1);

    wr(CLAIM1, 10); idle(3);
    check("R7 completion re-arms", 32'(irq0[1]), 32'h1);
    wr(24'h000028, 0); idle(1);
    check("R5 prio 0 silent", 32'(irq0[1]), 32'h0);
    rd(CLAIM0, r0, r1); check("R6 remaining", r0, 32'd7);

    // edge-mode instance
    wr(EN1, 32'h0010_0000); wr(24'h000050, 6);
    src1[20] = 1'b1; idle(3);
    check("R10 rising edge", 32'(irq1[1]), 32'h1);
    rd(CLAIM1, r0, r1); check("R10 claim id", r1, 32'd20);
    wr(CLAIM1, 20); idle(3);
    check("R10 held line no re-pend", 32'(irq1[1]), 32'h0);
    src1[20] = 1'b0; idle(1); src1[20] = 1'b1; idle(3);
    check("R10 new edge", 32'(irq1[1]), 32'h1);
    rd(CLAIM1, r0, r1); check("R10 claim again", r1, 32'd20);
    src1[20] = 1'b0; idle(1); src1[20] = 1'b1; idle(1);
    wr(CLAIM1, 20); idle(3);
    check("R10 edge during claim lost", 32'(irq1[1]), 32'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule